// File: doc/BRIEF.md
# Machine-Mode Trap and Control Register Unit

This block keeps the machine-level trap state of a small 32-bit RISC-V style core and runs exception entry and trap return. The execute stage reports an exception by pulsing a request together with a cause code and the program counter of the offending instruction. The unit then records that counter, the cause and a trap value in its registers. On the following cycle it presents a one-cycle redirect carrying the target address that the vector-base register held before the trap. A return request redirects to the saved exception counter instead.

The unit also serves single-cycle control-register reads and writes by 12-bit address. Read data is combinational. Read-only identity registers return zero, and an access to an unmapped address raises a flag. A small decoder watches the instruction in execute. It treats an immediate left shift that has bit 5 of its shift amount set as an illegal instruction. It blocks the destination write in that same cycle and starts a trap with the illegal-instruction cause.

Top module: `mtrap_unit`

## Requirements
- R1: After reset, `redirect_valid` is 0 and the vector-base (0x305), exception-PC (0x341) and cause (0x342) registers read 0.
- R2: A cycle with `exc_req`=1 is followed by exactly one cycle with `redirect_valid`=1, and `redirect_pc` in that cycle equals the vector-base value from before the trap edge.
- R3: On trap entry, the cause register (0x342) takes the cause zero-extended. The trap-value register (0x343) takes the full faulting PC. The exception-PC register (0x341) takes the faulting PC with bits [1:0] cleared. Cause codes: 0 fetch misaligned, 1 fetch access fault, 2 illegal instruction, 3 breakpoint, 4 load misaligned, 5 load access fault.
- R4: A `ret_req` cycle with no trap is followed by one `redirect_valid` cycle with `redirect_pc` equal to the exception-PC register.
- R5: Status (0x300), scratch (0x340), cause (0x342) and trap value (0x343) are fully writable, and a write reads back unchanged through `csr_rdata`.
- R6: The vector base (0x305) and exception PC (0x341) always read with bits [1:0] equal to 0, so only direct vectoring exists.
- R7: The identity registers 0xF11–0xF14, delegation (0x302), counter enable (0x306) and pending (0x344) read 0 and ignore writes. The ISA register (0x301) reads 0x40000000 (bit 30 set for a 32-bit base) and also ignores writes.
- R8: `csr_bad` is 1 while `csr_en`=1 and `csr_addr` is not one of the addresses above, and 0 for a mapped address.
- R9: When `ins_valid`=1 and `ins_word` has opcode bits [6:0]=0x13, funct3 bits [14:12]=1, bits [31:26]=0 and bit 25=1, then `rd_block` is 1 in that same cycle and a trap with cause 2 at `ins_pc` follows. When bit 25 is 0, no block and no trap occur.
- R10: Priority goes from an external exception, to the illegal shift, to a return. A trap update to the cause, trap-value or exception-PC register overrides a CSR write to that register in the same cycle.
- R11: A cycle with no exception, no illegal shift and no return is followed by `redirect_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request from execute |
| exc_cause | input | CAUSE_W | Cause code of the exception |
| exc_pc | input | XLEN | PC of the faulting instruction |
| ret_req | input | 1 | Trap-return request |
| ins_valid | input | 1 | Instruction in execute is valid |
| ins_word | input | 32 | Instruction word in execute |
| ins_pc | input | XLEN | PC of the instruction in execute |
| rd_block | output | 1 | Suppress the destination write (illegal shift) |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR write when 1, read when 0 |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| csr_bad | output | 1 | Unmapped CSR address |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | XLEN | Redirect target |

## Verification
The hardest case to reach from the ports is a collision, where a trap arrives in the same cycle as a return or as a CSR write to a trap register. Only one of the competing updates may land in the registers. The bench drives these requests together on one edge, both the exception-plus-return pair and the exception-plus-illegal-shift pair. It then reads the cause and trap-value registers back through the CSR port to show which update won. The illegal-shift path is reached by building exact immediate-shift encodings that differ only in bit 25.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

   typedef enum logic [3:0] {
      CAUSE_FETCH_ALIGN = 4'd0,
      CAUSE_FETCH_FAULT = 4'd1,
      CAUSE_ILLEGAL     = 4'd2,
      CAUSE_BREAK       = 4'd3,
      CAUSE_LOAD_ALIGN  = 4'd4,
      CAUSE_LOAD_FAULT  = 4'd5
   } cause_e;

   localparam logic [11:0] ADR_STATUS  = 12'h300;
   localparam logic [11:0] ADR_ISA     = 12'h301;
   localparam logic [11:0] ADR_DELEG   = 12'h302;
   localparam logic [11:0] ADR_VECTOR  = 12'h305;
   localparam logic [11:0] ADR_CNTEN   = 12'h306;
   localparam logic [11:0] ADR_SCRATCH = 12'h340;
   localparam logic [11:0] ADR_EPC     = 12'h341;
   localparam logic [11:0] ADR_CAUSE   = 12'h342;
   localparam logic [11:0] ADR_TVAL    = 12'h343;
   localparam logic [11:0] ADR_PEND    = 12'h344;
   localparam logic [11:0] ADR_ID_LO   = 12'hF11;
   localparam logic [11:0] ADR_ID_HI   = 12'hF14;

   localparam logic [6:0] OPC_OP_IMM = 7'h13;
   localparam logic [2:0] F3_SHL     = 3'b001;

endpackage

// File: rtl/mtrap_shift_check.sv
module mtrap_shift_check
   import mtrap_pkg::*;
(
   input  logic        ins_valid,
   input  logic [31:0] ins_word,
   output logic        bad_shift
);
   logic is_shl;

   always_comb begin
      is_shl    = (ins_word[6:0] == OPC_OP_IMM) && (ins_word[14:12] == F3_SHL)
                  && (ins_word[31:26] == 6'd0);
      bad_shift = ins_valid && is_shl && ins_word[25];
   end
endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file
   import mtrap_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned CAUSE_W  = 4,
   parameter logic [31:0] VEC_INIT = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_go,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic [XLEN-1:0]    trap_pc,
   input  logic               csr_en,
   input  logic               csr_we,
   input  logic [11:0]        csr_addr,
   input  logic [XLEN-1:0]    csr_wdata,
   output logic [XLEN-1:0]    csr_rdata,
   output logic               csr_bad,
   output logic [XLEN-1:0]    vec_base,
   output logic [XLEN-1:0]    epc_val
);
   localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);
   localparam logic [XLEN-1:0] ISA_CONST  = XLEN'(1) << (XLEN - 2);

   logic [XLEN-1:0] status_q, scratch_q, vec_q, epc_q, cause_q, tval_q;
   logic            hit;
   logic            wr;

   assign wr = csr_en && csr_we;

   always_comb begin
      hit       = 1'b1;
      csr_rdata = '0;
      unique case (csr_addr)
         ADR_STATUS:  csr_rdata = status_q;
         ADR_ISA:     csr_rdata = ISA_CONST;
         ADR_VECTOR:  csr_rdata = vec_q;
         ADR_SCRATCH: csr_rdata = scratch_q;
         ADR_EPC:     csr_rdata = epc_q;
         ADR_CAUSE:   csr_rdata = cause_q;
         ADR_TVAL:    csr_rdata = tval_q;
         ADR_DELEG, ADR_CNTEN, ADR_PEND: csr_rdata = '0;
         default: begin
            if (csr_addr >= ADR_ID_LO && csr_addr <= ADR_ID_HI) csr_rdata = '0;
            else hit = 1'b0;
         end
      endcase
      csr_bad = csr_en && !hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q  <= '0;
         scratch_q <= '0;
         vec_q     <= XLEN'(VEC_INIT) & ALIGN_MASK;
         epc_q     <= '0;
         cause_q   <= '0;
         tval_q    <= '0;
      end else begin
         if (wr && csr_addr == ADR_STATUS)  status_q  <= csr_wdata;
         if (wr && csr_addr == ADR_SCRATCH) scratch_q <= csr_wdata;
         if (wr && csr_addr == ADR_VECTOR)  vec_q     <= csr_wdata & ALIGN_MASK;
         if (trap_go) begin
            epc_q   <= trap_pc & ALIGN_MASK;
            cause_q <= XLEN'(trap_cause);
            tval_q  <= trap_pc;
         end else begin
            if (wr && csr_addr == ADR_EPC)   epc_q   <= csr_wdata & ALIGN_MASK;
            if (wr && csr_addr == ADR_CAUSE) cause_q <= csr_wdata;
            if (wr && csr_addr == ADR_TVAL)  tval_q  <= csr_wdata;
         end
      end
   end

   assign vec_base = vec_q;
   assign epc_val  = epc_q;

   // R3: a trap loads cause and trap value from the request of the previous cycle
   assert_trap_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_go |=> (cause_q == XLEN'($past(trap_cause))) && (tval_q == $past(trap_pc)));

   // R10: a competing CSR write to the cause register loses against a trap
   assert_trap_over_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_go && wr && csr_addr == ADR_CAUSE) |=> cause_q == XLEN'($past(trap_cause)));
endmodule

// File: rtl/mtrap_seq.sv
module mtrap_seq
   import mtrap_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_req,
   input  logic [CAUSE_W-1:0] exc_cause,
   input  logic [XLEN-1:0]    exc_pc,
   input  logic               shift_bad,
   input  logic [XLEN-1:0]    ins_pc,
   input  logic               ret_req,
   input  logic [XLEN-1:0]    vec_base,
   input  logic [XLEN-1:0]    epc_val,
   output logic               trap_go,
   output logic [CAUSE_W-1:0] trap_cause,
   output logic [XLEN-1:0]    trap_pc,
   output logic               redirect_valid,
   output logic [XLEN-1:0]    redirect_pc
);
   logic ret_go;

   always_comb begin
      trap_go = exc_req || shift_bad;
      ret_go  = ret_req && !trap_go;
      if (exc_req) begin
         trap_cause = exc_cause;
         trap_pc    = exc_pc;
      end else begin
         trap_cause = CAUSE_W'(CAUSE_ILLEGAL);
         trap_pc    = ins_pc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
      end else begin
         redirect_valid <= trap_go || ret_go;
         if (trap_go)     redirect_pc <= vec_base;
         else if (ret_go) redirect_pc <= epc_val;
      end
   end

   // R4: a lone return targets the saved exception PC
   assert_return_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !exc_req && !shift_bad) |=> redirect_valid && redirect_pc == $past(epc_val));

   // R2: a trap targets the vector base seen before the edge
   assert_trap_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> redirect_valid && redirect_pc == $past(vec_base));
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
   import mtrap_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned CAUSE_W     = 4,
   parameter logic [31:0] VEC_INIT    = 32'h0,
   parameter bit          SHIFT_CHECK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_req,
   input  logic [CAUSE_W-1:0] exc_cause,
   input  logic [XLEN-1:0]    exc_pc,
   input  logic               ret_req,
   input  logic               ins_valid,
   input  logic [31:0]        ins_word,
   input  logic [XLEN-1:0]    ins_pc,
   output logic               rd_block,
   input  logic               csr_en,
   input  logic               csr_we,
   input  logic [11:0]        csr_addr,
   input  logic [XLEN-1:0]    csr_wdata,
   output logic [XLEN-1:0]    csr_rdata,
   output logic               csr_bad,
   output logic               redirect_valid,
   output logic [XLEN-1:0]    redirect_pc
);
   if (XLEN != 32) begin : g_bad_xlen
      $error("mtrap_unit: XLEN must be 32");
   end
   if (CAUSE_W < 3 || CAUSE_W > XLEN) begin : g_bad_cause
      $error("mtrap_unit: CAUSE_W out of range");
   end

   logic               shift_bad;
   logic               trap_go;
   logic [CAUSE_W-1:0] trap_cause;
   logic [XLEN-1:0]    trap_pc;
   logic [XLEN-1:0]    vec_base;
   logic [XLEN-1:0]    epc_val;

   if (SHIFT_CHECK) begin : g_shift
      mtrap_shift_check u_shift (
         .ins_valid (ins_valid),
         .ins_word  (ins_word),
         .bad_shift (shift_bad)
      );
   end else begin : g_no_shift
      assign shift_bad = 1'b0;
   end

   assign rd_block = shift_bad;

   mtrap_seq #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .exc_req        (exc_req),
      .exc_cause      (exc_cause),
      .exc_pc         (exc_pc),
      .shift_bad      (shift_bad),
      .ins_pc         (ins_pc),
      .ret_req        (ret_req),
      .vec_base       (vec_base),
      .epc_val        (epc_val),
      .trap_go        (trap_go),
      .trap_cause     (trap_cause),
      .trap_pc        (trap_pc),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc)
   );

   mtrap_csr_file #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_INIT(VEC_INIT)) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .trap_go    (trap_go),
      .trap_cause (trap_cause),
      .trap_pc    (trap_pc),
      .csr_en     (csr_en),
      .csr_we     (csr_we),
      .csr_addr   (csr_addr),
      .csr_wdata  (csr_wdata),
      .csr_rdata  (csr_rdata),
      .csr_bad    (csr_bad),
      .vec_base   (vec_base),
      .epc_val    (epc_val)
   );

   // R11: no request of any kind means no redirect on the next cycle
   assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req && !ret_req && !rd_block) |=> !redirect_valid);

   // R9: a blocked shift always leads to a redirect
   assert_shift_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_block |=> redirect_valid);

   // R7: identity registers read zero
   assert_id_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && csr_addr >= ADR_ID_LO && csr_addr <= ADR_ID_HI) |-> csr_rdata == '0);

   // R6: exception PC never exposes low bits
   assert_epc_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && csr_addr == ADR_EPC) |-> csr_rdata[1:0] == 2'b00);
endmodule

// File: tb/sim_mtrap_unit.sv
module sim_mtrap_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [3:0]  exc_cause = '0;
   logic [31:0] exc_pc = '0;
   logic        ret_req = 1'b0;
   logic        ins_valid = 1'b0;
   logic [31:0] ins_word = '0;
   logic [31:0] ins_pc = '0;
   logic        rd_block;
   logic        csr_en = 1'b0;
   logic        csr_we = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        csr_bad;
   logic        redirect_valid;
   logic [31:0] redirect_pc;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mtrap_unit u0 (.*);

   localparam int NV = 10;
   localparam logic [11:0] V_ADR [NV] = '{12'h300, 12'h340, 12'h305, 12'h341, 12'h342,
                                          12'h343, 12'h301, 12'hF14, 12'h302, 12'h344};
   localparam logic [31:0] V_WR  [NV] = '{32'hDEADBEEF, 32'h12345678, 32'h00001003, 32'h80000007,
                                          32'h5, 32'hAAAA5555, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                          32'hFFFFFFFF, 32'hFFFFFFFF};
   localparam logic [31:0] V_EXP [NV] = '{32'hDEADBEEF, 32'h12345678, 32'h00001000, 32'h80000004,
                                          32'h5, 32'hAAAA5555, 32'h40000000, 32'h0,
                                          32'h0, 32'h0};
   localparam string V_REQ [NV] = '{"R5", "R5", "R6", "R6", "R5", "R5", "R7", "R7", "R7", "R7"};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
      csr_en = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_en = 1'b0; csr_we = 1'b0;
   endtask

   task automatic csr_rd(input logic [11:0] a, output logic [31:0] d, output logic b);
      csr_en = 1'b1; csr_we = 1'b0; csr_addr = a;
      #1;
      d = csr_rdata; b = csr_bad;
      @(negedge clk);
      csr_en = 1'b0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 valid", {31'd0, redirect_valid}, 32'd0);
      csr_rd(12'h305, d, b); chk("R1 vector", d, 32'h0);
      csr_rd(12'h341, d, b); chk("R1 epc", d, 32'h0);
      csr_rd(12'h342, d, b); chk("R1 cause", d, 32'h0);

      for (int i = 0; i < NV; i++) begin
         csr_wr(V_ADR[i], V_WR[i]);
         csr_rd(V_ADR[i], d, b);
         chk(V_REQ[i], d, V_EXP[i]);
         chk("R8 mapped", {31'd0, b}, 32'd0);
      end

      // R8 unmapped address
      csr_rd(12'h123, d, b); chk("R8 unmapped", {31'd0, b}, 32'd1);
      csr_rd(12'hF15, d, b); chk("R8 above id", {31'd0, b}, 32'd1);

      // R2/R3 exception entry
      csr_wr(12'h305, 32'h00000100);
      exc_req = 1'b1; exc_cause = 4'd4; exc_pc = 32'h00002002;
      @(negedge clk);
      exc_req = 1'b0;
      chk("R2 valid", {31'd0, redirect_valid}, 32'd1);
      chk("R2 target", redirect_pc, 32'h00000100);
      @(negedge clk);
      chk("R11 single pulse", {31'd0, redirect_valid}, 32'd0);
      csr_rd(12'h341, d, b); chk("R3 epc", d, 32'h00002000);
      csr_rd(12'h342, d, b); chk("R3 cause", d, 32'd4);
      csr_rd(12'h343, d, b); chk("R3 tval", d, 32'h00002002);

      // R4 return
      ret_req = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
      chk("R4 valid", {31'd0, redirect_valid}, 32'd1);
      chk("R4 target", redirect_pc, 32'h00002000);

      // R9 illegal shift
      ins_valid = 1'b1; ins_word = 32'h02309293; ins_pc = 32'h00003000;
      #1; chk("R9 block", {31'd0, rd_block}, 32'd1);
      @(negedge clk);
      ins_valid = 1'b0;
      chk("R9 redirect", redirect_pc, 32'h00000100);
      csr_rd(12'h342, d, b); chk("R9 cause", d, 32'd2);
      csr_rd(12'h343, d, b); chk("R9 tval", d, 32'h00003000);

      // R9 legal shift
      ins_valid = 1'b1; ins_word = 32'h00309293; ins_pc = 32'h00003004;
      #1; chk("R9 legal no block", {31'd0, rd_block}, 32'd0);
      @(negedge clk);
      ins_valid = 1'b0;
      chk("R9 legal no redirect", {31'd0, redirect_valid}, 32'd0);

      // R10 exception beats return
      exc_req = 1'b1; exc_cause = 4'd3; exc_pc = 32'h00000400; ret_req = 1'b1;
      @(negedge clk);
      exc_req = 1'b0; ret_req = 1'b0;
      chk("R10 exc over ret", redirect_pc, 32'h00000100);
      csr_rd(12'h342, d, b); chk("R10 cause", d, 32'd3);

      // R10 external exception beats illegal shift
      exc_req = 1'b1; exc_cause = 4'd1; exc_pc = 32'h00000500;
      ins_valid = 1'b1; ins_word = 32'h02309293; ins_pc = 32'h00000600;
      @(negedge clk);
      exc_req = 1'b0; ins_valid = 1'b0;
      csr_rd(12'h342, d, b); chk("R10 exc over shift cause", d, 32'd1);
      csr_rd(12'h343, d, b); chk("R10 exc over shift tval", d, 32'h00000500);

      // R10 trap beats CSR write
      exc_req = 1'b1; exc_cause = 4'd5; exc_pc = 32'h00000700;
      csr_en = 1'b1; csr_we = 1'b1; csr_addr = 12'h342; csr_wdata = 32'h9;
      @(negedge clk);
      exc_req = 1'b0; csr_en = 1'b0; csr_we = 1'b0;
      csr_rd(12'h342, d, b); chk("R10 trap over write", d, 32'd5);

      // R11 idle
      @(negedge clk);
      chk("R11 idle", {31'd0, redirect_valid}, 32'd0);

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule